// File: doc/BRIEF.md
# Countdown Timer Bank

A bank of independent down-counting timer channels sharing one memory-mapped register port. Each port access completes in a single cycle. Writes take effect at the clock edge. Reads are combinational from the current state.

Every channel has its own 0x40-byte window. The window holds a run-mode selector, a preset value, a run enable, a reload trigger, the live count, a pending/clear register and an interrupt mask. When an enabled counter sits at zero, it raises its pending flag. In periodic mode it then restarts from the preset. In single-shot mode it parks at zero and turns itself off.

Acknowledging an interrupt is not instantaneous. A clear request raises a busy flag for a fixed number of cycles, and further clear requests are ignored during that time. A terminal count that lands inside the busy window is preserved. A summary word at the bank base collects every channel's pending flag. Channel slot 4 is kept free for a separate watchdog: it reads as zero and ignores writes.

Top module: `cdt_bank`

## Requirements
- R1: After reset, every channel reads zero for mode, preset, enable, count and pending/clear. Every live channel's mask reads 1. All interrupt outputs are low.
- R2: Channel `s` occupies byte addresses `s*0x40` onward. Its register offsets are: mode 0x04 (bit 0: 0 periodic, 1 single-shot), preset 0x08, enable 0x10 (bit 0), reload 0x14, count 0x18, pending/clear 0x20, mask 0x24 (bit 0). The reload offset and any unmapped offset read as zero.
- R3: Writing the preset does not change the count. Any write to the reload offset, whatever its data, copies the preset into the count at that edge. This takes precedence over counting.
- R4: While enabled, the count drops by one per clock. While disabled, it holds.
- R5: In single-shot mode, an enabled clock with a count of zero sets pending, clears enable and leaves the count at zero. After enabling with preset L, pending appears L+1 clocks later.
- R6: In periodic mode, an enabled clock with a count of zero sets pending and reloads the preset, giving a period of L+1 clocks.
- R7: The pending/clear register reads pending in bit 0 and busy in bit 1. Writing bit 0 = 1 while not busy starts a clear. Writing bit 0 = 0 has no effect.
- R8: A clear holds busy for exactly 4 clocks. Pending and busy then drop on the same edge. Clear writes made while busy neither restart nor extend the clear.
- R9: A terminal count on any clock after the clear request, up to and including the clock on which busy drops, leaves pending set when busy drops.
- R10: Each interrupt output is high exactly when that channel is pending and its mask bit is 0.
- R11: Address 0x000 reads the pending flags of all slots in bits 0..7, with bits 8..31 at zero. Writes to this address change nothing.
- R12: Slot 4 reads zero at every offset, ignores all writes, keeps its interrupt low and shows 0 in the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| irq_out | output | 8 | Per-slot interrupt, pending and unmasked |

## Verification
A wrong count shows up on the count register in the very next cycle. A wrong terminal-count decision shows up as pending/irq appearing one clock early or late, or a periodic phase that drifts by one per period. A miscounting clear timer shows up as busy lasting 3 or 5 clocks instead of 4. A lost late event shows up as pending reading 0 right after busy falls. Any of these is visible at the register port within a single period of the small presets used here.

// File: rtl/cdt_pkg.sv
// Shared constants and types for the countdown timer bank.
// Assumes word-aligned accesses; offsets are decoded on the full window bits.
package cdt_pkg;
    localparam int OFF_W = 6;
    localparam logic [OFF_W-1:0] OFF_SUM    = 6'h00;
    localparam logic [OFF_W-1:0] OFF_MODE   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_LOAD   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_EN     = 6'h10;
    localparam logic [OFF_W-1:0] OFF_RELOAD = 6'h14;
    localparam logic [OFF_W-1:0] OFF_VALUE  = 6'h18;
    localparam logic [OFF_W-1:0] OFF_CLR    = 6'h20;
    localparam logic [OFF_W-1:0] OFF_MASK   = 6'h24;

    // Per-channel write strobes, one per writable register.
    typedef struct packed {
        logic mode;
        logic load;
        logic enable;
        logic reload;
        logic clear;
        logic mask;
    } chan_wr_t;
endpackage

// File: rtl/cdt_regdec.sv
// Write decoder: splits the byte address into slot and offset and raises
// one write strobe for the addressed register of the addressed slot.
// Assumes N_SLOTS <= 2**(ADDR_W-OFF_W).
module cdt_regdec
    import cdt_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int ADDR_W  = 9,
    localparam int SLOT_W = ADDR_W - OFF_W
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [SLOT_W-1:0] slot,
    output logic [OFF_W-1:0]  off,
    output chan_wr_t          wr_sel [N_SLOTS]
);
    assign slot = bus_addr[ADDR_W-1:OFF_W];
    assign off  = bus_addr[OFF_W-1:0];

    // Purpose: route a write access to exactly one channel register strobe.
    always_comb begin
        for (int s = 0; s < N_SLOTS; s++) begin
            wr_sel[s] = '0;
            if (bus_valid && bus_write && slot == SLOT_W'(s)) begin
                case (off)
                    OFF_MODE:   wr_sel[s].mode   = 1'b1;
                    OFF_LOAD:   wr_sel[s].load   = 1'b1;
                    OFF_EN:     wr_sel[s].enable = 1'b1;
                    OFF_RELOAD: wr_sel[s].reload = 1'b1;
                    OFF_CLR:    wr_sel[s].clear  = 1'b1;
                    OFF_MASK:   wr_sel[s].mask   = 1'b1;
                    default:    wr_sel[s]        = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cdt_channel.sv
// One countdown channel: preset, live counter, run mode, enable, mask and a
// pending flag whose clear takes CLR_CYCLES clocks behind a busy flag.
// Assumes CLR_CYCLES >= 1 and at most one write strobe per cycle.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int CLR_CYCLES = 4,
    localparam int CLW       = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_wr_t         wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             mode_o,
    output logic [CNT_W-1:0] load_o,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             busy_o,
    output logic             mask_o,
    output logic             irq_o
);
    logic             mode_q, en_q, pend_q, busy_q, mask_q, late_q;
    logic [CNT_W-1:0] load_q, cnt_q;
    logic [CLW-1:0]   left_q;
    logic             zero_evt, clr_start, clr_done;

    assign zero_evt  = en_q && (cnt_q == '0);
    assign clr_start = wr.clear && wdata[0] && !busy_q;
    assign clr_done  = busy_q && (left_q == '0);

    // Purpose: hold run mode and preset as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            load_q <= '0;
        end else begin
            if (wr.mode) mode_q <= wdata[0];
            if (wr.load) load_q <= wdata;
        end
    end

    // Purpose: mask register, blocking the interrupt out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b1;
        else if (wr.mask) mask_q <= wdata[0];
    end

    // Purpose: run enable; a single-shot terminal count turns it off.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= 1'b0;
        else if (wr.enable)          en_q <= wdata[0];
        else if (zero_evt && mode_q) en_q <= 1'b0;
    end

    // Purpose: counter with reload precedence, decrement and terminal action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr.reload) begin
            cnt_q <= load_q;
        end else if (en_q) begin
            if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
            else if (!mode_q) cnt_q <= load_q;
        end
    end

    // Purpose: clear handshake timer and record of events seen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            late_q <= 1'b0;
        end else if (clr_start) begin
            busy_q <= 1'b1;
            left_q <= CLW'(CLR_CYCLES - 1);
            late_q <= 1'b0;
        end else if (busy_q) begin
            if (left_q != '0) left_q <= left_q - 1'b1;
            else              busy_q <= 1'b0;
            if (zero_evt)     late_q <= 1'b1;
        end
    end

    // Purpose: pending flag, set on terminal count, dropped when a clear ends.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (clr_done) pend_q <= late_q | zero_evt;
        else if (zero_evt) pend_q <= 1'b1;
    end

    assign mode_o = mode_q;
    assign load_o = load_q;
    assign en_o   = en_q;
    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
    assign busy_o = busy_q;
    assign mask_o = mask_q;
    assign irq_o  = pend_q & ~mask_q;
endmodule

// File: rtl/cdt_readmux.sv
// Read multiplexer: returns the summary word at the bank base or the
// addressed channel register; anything else, or no read, returns zero.
// Assumes N_SLOTS <= CNT_W so the summary fits one word.
module cdt_readmux
    import cdt_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int CNT_W   = 32,
    parameter int SLOT_W  = 3
) (
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [OFF_W-1:0]  off,
    input  logic [N_SLOTS-1:0] mode_v,
    input  logic [N_SLOTS-1:0] en_v,
    input  logic [N_SLOTS-1:0] pend_v,
    input  logic [N_SLOTS-1:0] busy_v,
    input  logic [N_SLOTS-1:0] mask_v,
    input  logic [CNT_W-1:0]  load_a [N_SLOTS],
    input  logic [CNT_W-1:0]  cnt_a  [N_SLOTS],
    output logic [CNT_W-1:0]  rdata
);
    // Purpose: select the read word for the addressed slot and offset.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (slot == '0 && off == OFF_SUM) begin
                rdata[N_SLOTS-1:0] = pend_v;
            end else begin
                for (int s = 0; s < N_SLOTS; s++) begin
                    if (slot == SLOT_W'(s)) begin
                        case (off)
                            OFF_MODE:  rdata[0]   = mode_v[s];
                            OFF_LOAD:  rdata      = load_a[s];
                            OFF_EN:    rdata[0]   = en_v[s];
                            OFF_VALUE: rdata      = cnt_a[s];
                            OFF_CLR:   rdata[1:0] = {busy_v[s], pend_v[s]};
                            OFF_MASK:  rdata[0]   = mask_v[s];
                            default:   rdata      = '0;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cdt_bank.sv
// Top of the countdown timer bank: decoder, one channel per live slot
// (the reserved slot is tied off), and the read multiplexer.
// Assumes a single-cycle register port; reads are combinational.
module cdt_bank
    import cdt_pkg::*;
#(
    parameter int N_SLOTS    = 8,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 9,
    parameter int RSV_SLOT   = 4,
    parameter int CLR_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [N_SLOTS-1:0] irq_out
);
    localparam int SLOT_W = ADDR_W - OFF_W;

    logic [SLOT_W-1:0]  slot;
    logic [OFF_W-1:0]   off;
    chan_wr_t           wr_sel [N_SLOTS];
    logic [N_SLOTS-1:0] mode_v, en_v, pend_v, busy_v, mask_v, irq_v;
    logic [CNT_W-1:0]   load_a [N_SLOTS];
    logic [CNT_W-1:0]   cnt_a  [N_SLOTS];

    cdt_regdec #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .slot      (slot),
        .off       (off),
        .wr_sel    (wr_sel)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        if (s == RSV_SLOT) begin : g_rsv
            assign mode_v[s] = 1'b0;
            assign en_v[s]   = 1'b0;
            assign pend_v[s] = 1'b0;
            assign busy_v[s] = 1'b0;
            assign mask_v[s] = 1'b0;
            assign irq_v[s]  = 1'b0;
            assign load_a[s] = '0;
            assign cnt_a[s]  = '0;
        end else begin : g_ch
            cdt_channel #(.CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (wr_sel[s]),
                .wdata  (bus_wdata),
                .mode_o (mode_v[s]),
                .load_o (load_a[s]),
                .en_o   (en_v[s]),
                .cnt_o  (cnt_a[s]),
                .pend_o (pend_v[s]),
                .busy_o (busy_v[s]),
                .mask_o (mask_v[s]),
                .irq_o  (irq_v[s])
            );
        end
    end

    cdt_readmux #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_rd (
        .rd_en  (bus_valid && !bus_write),
        .slot   (slot),
        .off    (off),
        .mode_v (mode_v),
        .en_v   (en_v),
        .pend_v (pend_v),
        .busy_v (busy_v),
        .mask_v (mask_v),
        .load_a (load_a),
        .cnt_a  (cnt_a),
        .rdata  (bus_rdata)
    );

    assign irq_out = irq_v;
endmodule

// File: rtl/cdt_bank_chk.sv
// Property checker for the countdown timer bank, attached by bind.
module cdt_bank_chk #(
    parameter int N_SLOTS    = 8,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 9,
    parameter int RSV_SLOT   = 4,
    parameter int CLR_CYCLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [CNT_W-1:0]   bus_rdata,
    input logic [N_SLOTS-1:0] irq_out,
    input logic [N_SLOTS-1:0] pend_v,
    input logic [N_SLOTS-1:0] busy_v
);
    localparam int OW = 6;

    // R11
    summary_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0) |-> ((bus_rdata >> N_SLOTS) == '0));

    if (RSV_SLOT < N_SLOTS) begin : g_rsv
        // R12
        rsv_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_out[RSV_SLOT]);
        // R12
        rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_write && bus_addr[ADDR_W-1:OW] == (ADDR_W-OW)'(RSV_SLOT))
            |-> (bus_rdata == '0));
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_ch
        // R8
        pend_drop_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_v[s]) |-> $fell(busy_v[s]));
        if (CLR_CYCLES > 1) begin : g_long
            // R8
            busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(busy_v[s]) |=> busy_v[s]);
        end
    end
endmodule

bind cdt_bank cdt_bank_chk #(
    .N_SLOTS(N_SLOTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .RSV_SLOT(RSV_SLOT), .CLR_CYCLES(CLR_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .pend_v(pend_v), .busy_v(busy_v)
);

// File: tb/test_cdt_bank.sv
`timescale 1ns/1ps
module test_cdt_bank;
    localparam int MODE = 'h04, LOAD = 'h08, EN = 'h10, RELOAD = 'h14;
    localparam int VALUE = 'h18, CLR = 'h20, MASK = 'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_out;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    cdt_bank i_cdt_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int s, input int off, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 9'(s * 64 + off); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int s, input int off, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 9'(s * 64 + off);
        #0.01;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rdchk(input string req, input int s, input int off, input logic [31:0] exp);
        logic [31:0] d;
        rd(s, off, d);
        check(req, d, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 reset state and map
        for (int s = 0; s < 8; s++) begin
            rdchk("R1 mode", s, MODE, 0);
            rdchk("R1 load", s, LOAD, 0);
            rdchk("R1 en", s, EN, 0);
            rdchk("R1 value", s, VALUE, 0);
            rdchk("R1 clr", s, CLR, 0);
            rdchk("R1 mask", s, MASK, (s == 4) ? 0 : 1);
            rdchk("R2 reload reads 0", s, RELOAD, 0);
            tick();
        end
        rdchk("R11 summary reset", 0, 0, 0);
        check("R1 irq", 32'(irq_out), 0);

        // R3 preset write alone leaves count
        wr(1, LOAD, 20);
        rdchk("R3 load no count", 1, VALUE, 0);
        rdchk("R2 load readback", 1, LOAD, 20);
        rdchk("R2 unmapped", 1, 'h0C, 0);

        // R5 single-shot on channel 0, preset 5
        wr(0, MODE, 1);
        wr(0, LOAD, 5);
        wr(0, RELOAD, 32'hDEADBEEF);
        rdchk("R3 reload any data", 0, VALUE, 5);
        wr(0, EN, 1);
        rdchk("R4 start", 0, VALUE, 5);
        for (int k = 1; k <= 5; k++) begin
            tick();
            rdchk("R4 countdown", 0, VALUE, 32'(5 - k));
            rdchk("R5 not yet pending", 0, CLR, 0);
        end
        tick();
        rdchk("R5 pending", 0, CLR, 1);
        rdchk("R5 en cleared", 0, EN, 0);
        rdchk("R5 value zero", 0, VALUE, 0);
        tick();
        rdchk("R5 hold zero", 0, VALUE, 0);
        rdchk("R11 summary ch0", 0, 0, 1);
        check("R10 masked", 32'(irq_out), 0);
        wr(0, MASK, 0);
        check("R10 unmasked", 32'(irq_out), 1);
        wr(0, CLR, 0);
        rdchk("R7 write 0 no effect", 0, CLR, 1);
        wr(0, CLR, 1);
        rdchk("R7 busy", 0, CLR, 3);
        wr(0, CLR, 1);
        rdchk("R8 busy 2", 0, CLR, 3);
        tick();
        rdchk("R8 busy 3", 0, CLR, 3);
        tick();
        rdchk("R8 busy 4", 0, CLR, 3);
        tick();
        rdchk("R8 done", 0, CLR, 0);
        check("R10 irq after clear", 32'(irq_out), 0);

        // R6 R9 periodic on channel 3, preset 7
        wr(3, LOAD, 7);
        wr(3, RELOAD, 0);
        wr(3, MASK, 0);
        wr(3, EN, 1);
        for (int k = 1; k <= 20; k++) begin
            if (k == 9 || k == 14) wr(3, CLR, 1);
            else tick();
            rdchk("R6 periodic count", 3, VALUE, 32'(7 - (k % 8)));
            if (k == 8) begin
                rdchk("R6 pending", 3, CLR, 1);
                check("R10 irq ch3", 32'(irq_out), 32'h8);
            end
            if (k == 9)  rdchk("R7 busy ch3", 3, CLR, 3);
            if (k == 13) rdchk("R8 cleared ch3", 3, CLR, 0);
            if (k == 14) rdchk("R8 busy no pend", 3, CLR, 2);
            if (k == 16) rdchk("R9 event during busy", 3, CLR, 3);
            if (k == 18) rdchk("R9 event kept", 3, CLR, 1);
        end
        wr(3, RELOAD, 32'h1234);
        rdchk("R3 reload beats count", 3, VALUE, 7);
        wr(3, EN, 0);
        rdchk("R4 last decrement", 3, VALUE, 6);
        tick(); tick();
        rdchk("R4 disabled hold", 3, VALUE, 6);

        // R11 summary is read-only
        rdchk("R11 summary ch3", 0, 0, 8);
        wr(0, 0, 32'hFFFFFFFF);
        rdchk("R11 write ignored", 0, 0, 8);
        rdchk("R11 mode untouched", 0, MODE, 1);
        wr(3, CLR, 1);
        repeat (4) tick();
        rdchk("R8 ch3 clear", 3, CLR, 0);

        // R12 reserved slot
        wr(4, LOAD, 9);
        wr(4, RELOAD, 0);
        wr(4, MASK, 0);
        wr(4, MODE, 1);
        wr(4, EN, 1);
        repeat (12) tick();
        rdchk("R12 load", 4, LOAD, 0);
        rdchk("R12 value", 4, VALUE, 0);
        rdchk("R12 en", 4, EN, 0);
        rdchk("R12 clr", 4, CLR, 0);
        tick();
        rdchk("R12 mode", 4, MODE, 0);
        rdchk("R12 summary", 0, 0, 0);
        check("R12 irq", 32'(irq_out), 0);

        // R5 R10 sweep over live slots and small presets
        for (int s = 0; s < 8; s++) begin
            if (s == 4) continue;
            for (int l = 0; l < 4; l++) begin
                wr(s, MODE, 1);
                wr(s, LOAD, 32'(l));
                wr(s, RELOAD, 0);
                wr(s, MASK, 0);
                wr(s, EN, 1);
                for (int j = 1; j <= l + 1; j++) begin
                    tick();
                    rdchk("R5 sweep pending", s, CLR, (j == l + 1) ? 1 : 0);
                    check("R10 sweep irq", 32'(irq_out), (j == l + 1) ? (32'h1 << s) : 0);
                end
                rdchk("R5 sweep en off", s, EN, 0);
                rdchk("R11 sweep summary", 0, 0, 32'h1 << s);
                wr(s, CLR, 1);
                repeat (4) tick();
                rdchk("R8 sweep cleared", s, CLR, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule